// File: doc/BRIEF.md
# Memory Access Ordering Queue

This block sits between the in-order issue stage of a dynamically scheduled core and the data cache. Every memory access is entered in program order into one of two circular queues: reads go to the read queue and writes to the write queue. Each entry is filled in later, in any order, with its doubleword address (and, for writes, its data). The block then drives the cache port and returns read results. A fresh entry records which entries of the other queue were already present when it was entered, because those are exactly the accesses that precede it in program order.

Reads leave the read queue strictly from its head and writes leave the write queue strictly from its head. A read whose address equals that of an older queued write takes the data of the youngest such write and never touches the cache. A read is held while any older write still lacks its address. A write is held while any older read that has not yet finished names the same address or still has no address. Since only the head of each queue may use the port, two writes to one location reach the cache in program order.

Top module: `lsq_disambig`

## Requirements
- R1: After reset both queues are empty, the allocation-ready output is high for either access kind, and neither a cache request nor a read result is signalled.
- R2: An accepted allocation takes the tail slot of its queue and reports that slot index on `alloc_idx`. Slots run 0, 1, 2, … and wrap after DEPTH-1. Allocation-ready is low for an access kind exactly when its queue holds DEPTH entries.
- R3: A read whose doubleword address equals that of an older write still in the write queue returns that write's data with `ld_res_forwarded` = 1 and issues no cache read.
- R4: When several older queued writes match a read, the data comes from the youngest of them in program order.
- R5: A read with no matching older queued write issues a cache read (`mem_req_write` = 0). It returns the cache response data with `ld_res_forwarded` = 0 one cycle after the response, and only one cache read is outstanding at a time.
- R6: A read produces no cache access and no result while any older write in the write queue has no address yet.
- R7: Writes reach the cache one per request in program order, so after all accesses finish every location holds the value of its youngest write in program order.
- R8: A write is not sent to the cache while an older unfinished read names the same address or has no address yet, so that read sees the value from before the write.
- R9: Read results appear in program order; `ld_res_idx` gives the read-queue slot and follows the allocation order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Enter one access in program order |
| alloc_store | input | 1 | 1: the access is a write, 0: a read |
| alloc_ready | output | 1 | The queue chosen by `alloc_store` has a free slot |
| alloc_idx | output | $clog2(DEPTH) | Slot index given to the access |
| ld_addr_valid | input | 1 | Address arrives for a read slot |
| ld_addr_idx | input | $clog2(DEPTH) | Read slot receiving the address |
| ld_addr | input | AW | Read doubleword address |
| st_addr_valid | input | 1 | Address and data arrive for a write slot |
| st_addr_idx | input | $clog2(DEPTH) | Write slot receiving them |
| st_addr | input | AW | Write doubleword address |
| st_data | input | DW | Write data |
| mem_req_valid | output | 1 | Cache access this cycle (always accepted) |
| mem_req_write | output | 1 | 1: write, 0: read |
| mem_req_addr | output | AW | Cache doubleword address |
| mem_req_wdata | output | DW | Cache write data |
| mem_rsp_valid | input | 1 | Read data returned, one cycle after a read request |
| mem_rsp_data | input | DW | Returned read data |
| ld_res_valid | output | 1 | A read result is presented |
| ld_res_idx | output | $clog2(DEPTH) | Read slot of the result |
| ld_res_data | output | DW | Read value |
| ld_res_forwarded | output | 1 | 1: value taken from a queued write |

## Verification
Many short batches of up to eight mixed accesses are drawn from four addresses, so conflicts occur often. Their addresses are delivered in program order, in reverse order and in rotated order. Each read is compared with a program-order model, and the whole cache contents are compared after each batch. This separates correct ordering from forwarding from the wrong write, and from reads or writes that slip past an older access. Directed sequences each isolate one mechanism: a full read queue, a read stalled behind a write with no address, a read choosing among two matching writes while an older read holds them in the queue, and a write held behind an older read to the same address.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    // Operation placed on the single cache port in a cycle.
    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_READ  = 2'd1,
        PORT_WRITE = 2'd2
    } port_op_e;

endpackage

// File: rtl/lsq_addr_match.sv
// Compares one key address against every slot of a queue.
module lsq_addr_match #(
    parameter int N  = 8,
    parameter int AW = 13
) (
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [N-1:0]         en,
    input  logic [AW-1:0]        key,
    output logic [N-1:0]         hit
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = en[g] && (tags[g] == key);
    end

endmodule

// File: rtl/lsq_youngest_pick.sv
// Returns the hit slot furthest from the head, which is the youngest entry.
module lsq_youngest_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0]         mask,
    input  logic [$clog2(N)-1:0] head,
    output logic [$clog2(N)-1:0] slot
);

    localparam int IW = $clog2(N);

    always_comb begin
        slot = head;
        for (int k = 0; k < N; k++) begin
            if (mask[head + IW'(k)]) begin
                slot = head + IW'(k);
            end
        end
    end

endmodule

// File: rtl/lsq_disambig.sv
module lsq_disambig
    import lsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 13,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_valid,
    input  logic                     alloc_store,
    output logic                     alloc_ready,
    output logic [$clog2(DEPTH)-1:0] alloc_idx,
    input  logic                     ld_addr_valid,
    input  logic [$clog2(DEPTH)-1:0] ld_addr_idx,
    input  logic [AW-1:0]            ld_addr,
    input  logic                     st_addr_valid,
    input  logic [$clog2(DEPTH)-1:0] st_addr_idx,
    input  logic [AW-1:0]            st_addr,
    input  logic [DW-1:0]            st_data,
    output logic                     mem_req_valid,
    output logic                     mem_req_write,
    output logic [AW-1:0]            mem_req_addr,
    output logic [DW-1:0]            mem_req_wdata,
    input  logic                     mem_rsp_valid,
    input  logic [DW-1:0]            mem_rsp_data,
    output logic                     ld_res_valid,
    output logic [$clog2(DEPTH)-1:0] ld_res_idx,
    output logic [DW-1:0]            ld_res_data,
    output logic                     ld_res_forwarded
);

    localparam int IW = $clog2(DEPTH);

    // Per-slot "older" masks: rd_old[i][j] = write slot j precedes read slot i,
    // wr_old[i][j] = read slot j precedes write slot i.
    typedef struct packed {
        logic [DEPTH-1:0]                rd_vld;
        logic [DEPTH-1:0]                rd_known;
        logic [DEPTH-1:0][AW-1:0]        rd_addr;
        logic [DEPTH-1:0][DEPTH-1:0]     rd_old;
        logic [IW-1:0]                   rd_head;
        logic [IW-1:0]                   rd_tail;
        logic [DEPTH-1:0]                wr_vld;
        logic [DEPTH-1:0]                wr_known;
        logic [DEPTH-1:0][AW-1:0]        wr_addr;
        logic [DEPTH-1:0][DW-1:0]        wr_data;
        logic [DEPTH-1:0][DEPTH-1:0]     wr_old;
        logic [IW-1:0]                   wr_head;
        logic [IW-1:0]                   wr_tail;
        logic                            rd_wait;
        logic                            res_vld;
        logic [IW-1:0]                   res_idx;
        logic [DW-1:0]                   res_data;
        logic                            res_fwd;
    } state_t;

    state_t state_q, state_d;

    logic [IW-1:0]    rh, wh;
    logic [DEPTH-1:0] rd_prior_wr, wr_prior_rd;
    logic [DEPTH-1:0] fwd_hits, war_hits;
    logic [IW-1:0]    fwd_slot;
    logic             rd_ready, addr_unknown, rd_go, rd_fwd, rd_mem, rd_done;
    logic             war_block, wr_go, wr_is_older;
    port_op_e         port_op;

    assign rh = state_q.rd_head;
    assign wh = state_q.wr_head;

    // ---------------- read head: forwarding search over the write queue
    assign rd_prior_wr  = state_q.rd_old[rh] & state_q.wr_vld;
    assign addr_unknown = |(rd_prior_wr & ~state_q.wr_known);

    lsq_addr_match #(.N(DEPTH), .AW(AW)) u_fwd_match (
        .tags (state_q.wr_addr),
        .en   (rd_prior_wr & state_q.wr_known),
        .key  (state_q.rd_addr[rh]),
        .hit  (fwd_hits)
    );

    lsq_youngest_pick #(.N(DEPTH)) u_fwd_pick (
        .mask (fwd_hits),
        .head (wh),
        .slot (fwd_slot)
    );

    assign rd_ready = state_q.rd_vld[rh] && state_q.rd_known[rh] && !state_q.rd_wait;
    assign rd_go    = rd_ready && !addr_unknown;
    assign rd_fwd   = rd_go && (|fwd_hits);
    assign rd_mem   = rd_go && !(|fwd_hits);
    assign rd_done  = rd_fwd || (state_q.rd_wait && mem_rsp_valid);

    // ---------------- write head: anti-dependence search over the read queue
    assign wr_prior_rd = state_q.wr_old[wh] & state_q.rd_vld;

    lsq_addr_match #(.N(DEPTH), .AW(AW)) u_war_match (
        .tags (state_q.rd_addr),
        .en   (wr_prior_rd & state_q.rd_known),
        .key  (state_q.wr_addr[wh]),
        .hit  (war_hits)
    );

    assign war_block   = (|war_hits) || (|(wr_prior_rd & ~state_q.rd_known));
    assign wr_go       = state_q.wr_vld[wh] && state_q.wr_known[wh] && !war_block;
    assign wr_is_older = rd_prior_wr[wh];

    // ---------------- cache port arbitration: older access wins
    always_comb begin
        if (wr_go && (!rd_mem || wr_is_older)) begin
            port_op = PORT_WRITE;
        end else if (rd_mem) begin
            port_op = PORT_READ;
        end else begin
            port_op = PORT_IDLE;
        end
    end

    assign mem_req_valid = (port_op != PORT_IDLE);
    assign mem_req_write = (port_op == PORT_WRITE);
    assign mem_req_addr  = (port_op == PORT_WRITE) ? state_q.wr_addr[wh] : state_q.rd_addr[rh];
    assign mem_req_wdata = state_q.wr_data[wh];

    // ---------------- allocation
    assign alloc_ready = alloc_store ? !state_q.wr_vld[state_q.wr_tail]
                                     : !state_q.rd_vld[state_q.rd_tail];
    assign alloc_idx   = alloc_store ? state_q.wr_tail : state_q.rd_tail;

    // ---------------- next state
    always_comb begin
        state_d         = state_q;
        state_d.res_vld = 1'b0;

        if (ld_addr_valid) begin
            state_d.rd_known[ld_addr_idx] = 1'b1;
            state_d.rd_addr[ld_addr_idx]  = ld_addr;
        end
        if (st_addr_valid) begin
            state_d.wr_known[st_addr_idx] = 1'b1;
            state_d.wr_addr[st_addr_idx]  = st_addr;
            state_d.wr_data[st_addr_idx]  = st_data;
        end

        if (rd_done) begin
            state_d.res_vld    = 1'b1;
            state_d.res_idx    = rh;
            state_d.res_fwd    = rd_fwd;
            state_d.res_data   = rd_fwd ? state_q.wr_data[fwd_slot] : mem_rsp_data;
            state_d.rd_wait    = 1'b0;
            state_d.rd_vld[rh] = 1'b0;
            state_d.rd_head    = rh + IW'(1);
            for (int i = 0; i < DEPTH; i++) begin
                state_d.wr_old[i][rh] = 1'b0;
            end
        end

        if (port_op == PORT_READ) begin
            state_d.rd_wait = 1'b1;
        end

        if (port_op == PORT_WRITE) begin
            state_d.wr_vld[wh] = 1'b0;
            state_d.wr_head    = wh + IW'(1);
            for (int i = 0; i < DEPTH; i++) begin
                state_d.rd_old[i][wh] = 1'b0;
            end
        end

        if (alloc_valid && alloc_ready) begin
            if (alloc_store) begin
                state_d.wr_vld[state_q.wr_tail]   = 1'b1;
                state_d.wr_known[state_q.wr_tail] = 1'b0;
                state_d.wr_old[state_q.wr_tail]   = state_d.rd_vld;
                state_d.wr_tail                   = state_q.wr_tail + IW'(1);
            end else begin
                state_d.rd_vld[state_q.rd_tail]   = 1'b1;
                state_d.rd_known[state_q.rd_tail] = 1'b0;
                state_d.rd_old[state_q.rd_tail]   = state_d.wr_vld;
                state_d.rd_tail                   = state_q.rd_tail + IW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ld_res_valid     = state_q.res_vld;
    assign ld_res_idx       = state_q.res_idx;
    assign ld_res_data      = state_q.res_data;
    assign ld_res_forwarded = state_q.res_fwd;

endmodule

// File: rtl/lsq_disambig_chk.sv
module lsq_disambig_chk #(
    parameter int DEPTH = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     alloc_valid,
    input logic                     alloc_store,
    input logic                     alloc_ready,
    input logic                     mem_req_valid,
    input logic                     mem_req_write,
    input logic                     mem_rsp_valid,
    input logic                     ld_res_valid,
    input logic [$clog2(DEPTH)-1:0] ld_res_idx,
    input logic                     ld_res_forwarded,
    input logic [DEPTH-1:0]         rd_vld,
    input logic [DEPTH-1:0]         wr_vld,
    input logic [$clog2(DEPTH)-1:0] wr_head,
    input logic                     rd_wait
);

    localparam int IW = $clog2(DEPTH);

    logic [IW-1:0] res_cnt_q, wr_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_cnt_q <= '0;
            wr_cnt_q  <= '0;
        end else begin
            if (ld_res_valid) res_cnt_q <= res_cnt_q + IW'(1);
            if (mem_req_valid && mem_req_write) wr_cnt_q <= wr_cnt_q + IW'(1);
        end
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mem_req_valid && !ld_res_valid));

    assert_read_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_store && !alloc_ready) |-> ($countones(rd_vld) == DEPTH));

    assert_write_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_store && !alloc_ready) |-> ($countones(wr_vld) == DEPTH));

    assert_one_read_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wait |-> !(mem_req_valid && !mem_req_write));

    assert_response_returned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |=> (ld_res_valid && !ld_res_forwarded));

    assert_writes_in_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (wr_head == wr_cnt_q));

    assert_results_in_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_res_valid |-> (ld_res_idx == res_cnt_q));

endmodule

bind lsq_disambig lsq_disambig_chk #(.DEPTH(DEPTH)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .alloc_valid      (alloc_valid),
    .alloc_store      (alloc_store),
    .alloc_ready      (alloc_ready),
    .mem_req_valid    (mem_req_valid),
    .mem_req_write    (mem_req_write),
    .mem_rsp_valid    (mem_rsp_valid),
    .ld_res_valid     (ld_res_valid),
    .ld_res_idx       (ld_res_idx),
    .ld_res_forwarded (ld_res_forwarded),
    .rd_vld           (state_q.rd_vld),
    .wr_vld           (state_q.wr_vld),
    .wr_head          (state_q.wr_head),
    .rd_wait          (state_q.rd_wait)
);

// File: tb/tb_lsq_disambig.sv
module tb_lsq_disambig;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int AW         = 13;
    localparam int DW         = 32;
    localparam int IW         = $clog2(DEPTH);
    localparam int MEMN       = 16;
    localparam int NBATCH     = 250;

    logic clk, rst_n;
    logic alloc_valid, alloc_store, alloc_ready;
    logic [IW-1:0] alloc_idx;
    logic ld_addr_valid;
    logic [IW-1:0] ld_addr_idx;
    logic [AW-1:0] ld_addr;
    logic st_addr_valid;
    logic [IW-1:0] st_addr_idx;
    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_data;
    logic mem_req_valid, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic mem_rsp_valid;
    logic [DW-1:0] mem_rsp_data;
    logic ld_res_valid, ld_res_forwarded;
    logic [IW-1:0] ld_res_idx;
    logic [DW-1:0] ld_res_data;

    lsq_disambig #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_store(alloc_store),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .ld_addr_valid(ld_addr_valid), .ld_addr_idx(ld_addr_idx), .ld_addr(ld_addr),
        .st_addr_valid(st_addr_valid), .st_addr_idx(st_addr_idx),
        .st_addr(st_addr), .st_data(st_data),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .ld_res_valid(ld_res_valid), .ld_res_idx(ld_res_idx),
        .ld_res_data(ld_res_data), .ld_res_forwarded(ld_res_forwarded)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int            exp_n = 0;
    int            got_n = 0;
    logic [DW-1:0] exp_data [8192];
    int            exp_idx  [8192];
    int            exp_fwd  [8192];

    logic [DW-1:0] ref_mem [MEMN];
    logic [DW-1:0] mem     [MEMN];
    logic [31:0]   rng = 32'h1234_5679;

    int            op_st   [8];
    logic [AW-1:0] op_addr [8];
    logic [DW-1:0] op_data [8];
    logic [IW-1:0] op_idx  [8];

    function automatic logic [DW-1:0] seed_word(input int i);
        return 32'h5A00_0000 + 32'(i) * 32'h0001_0103;
    endfunction

    // Cache model: writes land at the edge, reads answer one cycle later.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            for (int i = 0; i < MEMN; i++) mem[i] <= seed_word(i);
        end else begin
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid) begin
                if (mem_req_write) begin
                    mem[mem_req_addr[3:0]] <= mem_req_wdata;
                end else begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= mem[mem_req_addr[3:0]];
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Result monitor, sampled away from the rising edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && ld_res_valid === 1'b1) begin
            if (got_n >= exp_n) begin
                check(0, "R9", "unexpected read result", ld_res_idx, 0);
            end else begin
                check(ld_res_data == exp_data[got_n], "R3 R4 R5 R7 R8",
                      "read value", ld_res_data, exp_data[got_n]);
                check(int'(ld_res_idx) == exp_idx[got_n], "R9", "result slot order",
                      ld_res_idx, exp_idx[got_n]);
                if (exp_fwd[got_n] >= 0) begin
                    check(int'(ld_res_forwarded) == exp_fwd[got_n], "R3 R5",
                          "forwarded flag", ld_res_forwarded, exp_fwd[got_n]);
                end
                got_n++;
            end
        end
    end

    function automatic logic [31:0] next_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    task automatic do_alloc(input logic st, output logic [IW-1:0] idx);
        @(negedge clk);
        alloc_valid = 1'b1;
        alloc_store = st;
        #1;
        idx = alloc_idx;
        check(alloc_ready, "R2", "allocation accepted", alloc_ready, 1);
        @(posedge clk);
        #1;
        alloc_valid = 1'b0;
    endtask

    task automatic give_rd(input logic [IW-1:0] idx, input logic [AW-1:0] a);
        @(negedge clk);
        ld_addr_valid = 1'b1;
        ld_addr_idx   = idx;
        ld_addr       = a;
        @(posedge clk);
        #1;
        ld_addr_valid = 1'b0;
    endtask

    task automatic give_wr(input logic [IW-1:0] idx, input logic [AW-1:0] a,
                           input logic [DW-1:0] v);
        @(negedge clk);
        st_addr_valid = 1'b1;
        st_addr_idx   = idx;
        st_addr       = a;
        st_data       = v;
        @(posedge clk);
        #1;
        st_addr_valid = 1'b0;
    endtask

    // Program-order model.
    task automatic model_wr(input logic [AW-1:0] a, input logic [DW-1:0] v);
        ref_mem[a[3:0]] = v;
    endtask

    task automatic model_rd(input logic [AW-1:0] a, input logic [IW-1:0] idx, input int fwd);
        exp_data[exp_n] = ref_mem[a[3:0]];
        exp_idx[exp_n]  = int'(idx);
        exp_fwd[exp_n]  = fwd;
        exp_n++;
    endtask

    task automatic wait_drain();
        int t = 0;
        while (got_n < exp_n && t < 400) begin
            @(negedge clk);
            t++;
        end
        repeat (12) @(negedge clk);
        check(got_n == exp_n, "R9", "all reads answered", got_n, exp_n);
    endtask

    task automatic check_mem(input string req);
        for (int i = 0; i < MEMN; i++) begin
            check(mem[i] == ref_mem[i], req, "cache word", mem[i], ref_mem[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [IW-1:0] ix, s1, s2, s3, l0, l4;
        int            g0;
        logic [DW-1:0] old9;

        rst_n = 1'b0;
        alloc_valid = 1'b0; alloc_store = 1'b0;
        ld_addr_valid = 1'b0; ld_addr_idx = '0; ld_addr = '0;
        st_addr_valid = 1'b0; st_addr_idx = '0; st_addr = '0; st_data = '0;
        for (int i = 0; i < MEMN; i++) ref_mem[i] = seed_word(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(mem_req_valid == 1'b0, "R1", "no cache request", mem_req_valid, 0);
        check(ld_res_valid == 1'b0, "R1", "no result", ld_res_valid, 0);
        alloc_store = 1'b0; #1;
        check(alloc_ready == 1'b1, "R1", "read queue ready", alloc_ready, 1);
        alloc_store = 1'b1; #1;
        check(alloc_ready == 1'b1, "R1", "write queue ready", alloc_ready, 1);
        alloc_store = 1'b0;

        // R2 + R5 + R9: fill the read queue, addresses in reverse order
        for (int i = 0; i < DEPTH; i++) begin
            do_alloc(1'b0, ix);
            op_idx[i] = ix;
            check(int'(ix) == i, "R2", "slot index", ix, i);
        end
        alloc_store = 1'b0; #1;
        check(alloc_ready == 1'b0, "R2", "full read queue not ready", alloc_ready, 0);
        alloc_store = 1'b1; #1;
        check(alloc_ready == 1'b1, "R2", "write queue still ready", alloc_ready, 1);
        alloc_store = 1'b0;
        for (int i = 0; i < DEPTH; i++) model_rd(AW'(i), op_idx[i], 0);
        for (int i = DEPTH - 1; i >= 0; i--) give_rd(op_idx[i], AW'(i));
        wait_drain();

        // R6 then R3: read waits for an older write's address, then forwards
        do_alloc(1'b1, s1);
        do_alloc(1'b0, l0);
        model_wr(AW'(5), 32'hCAFE_0005);
        model_rd(AW'(5), l0, 1);
        give_rd(l0, AW'(5));
        g0 = got_n;
        repeat (6) @(negedge clk);
        check(got_n == g0, "R6", "read held behind unknown write address", got_n, g0);
        give_wr(s1, AW'(5), 32'hCAFE_0005);
        wait_drain();
        check_mem("R7");

        // R4: two matching older writes held by an older read to the same address
        do_alloc(1'b0, l0);
        do_alloc(1'b1, s1);
        do_alloc(1'b1, s2);
        do_alloc(1'b1, s3);
        do_alloc(1'b0, l4);
        model_rd(AW'(3), l0, 0);
        model_wr(AW'(3), 32'h1111_0001);
        model_wr(AW'(3), 32'h2222_0002);
        model_wr(AW'(7), 32'h3333_0003);
        model_rd(AW'(3), l4, 1);
        give_wr(s1, AW'(3), 32'h1111_0001);
        give_wr(s2, AW'(3), 32'h2222_0002);
        give_wr(s3, AW'(7), 32'h3333_0003);
        give_rd(l4, AW'(3));
        give_rd(l0, AW'(3));
        wait_drain();
        check_mem("R4 R7");

        // R8: write held behind an older read to the same address
        old9 = ref_mem[9];
        do_alloc(1'b0, l0);
        do_alloc(1'b1, s1);
        model_rd(AW'(9), l0, 0);
        model_wr(AW'(9), 32'hBEEF_0009);
        give_wr(s1, AW'(9), 32'hBEEF_0009);
        repeat (6) @(negedge clk);
        check(mem[9] == old9, "R8", "write held before older read", mem[9], old9);
        give_rd(l0, AW'(9));
        wait_drain();
        check_mem("R8");

        // Mixed batches over a few addresses, three address-delivery orders
        for (int b = 0; b < NBATCH; b++) begin
            int n, mode, rot;
            n = 3 + int'(next_rng() % 6);
            mode = b % 3;
            rot = b % n;
            for (int i = 0; i < n; i++) begin
                logic [31:0] r;
                r = next_rng();
                op_st[i]   = int'(r[0]);
                op_addr[i] = AW'(4 * (b % 4)) + AW'(r[3:2]);
                op_data[i] = next_rng();
            end
            for (int i = 0; i < n; i++) do_alloc(op_st[i][0], op_idx[i]);
            for (int i = 0; i < n; i++) begin
                if (op_st[i] != 0) model_wr(op_addr[i], op_data[i]);
                else model_rd(op_addr[i], op_idx[i], -1);
            end
            for (int j = 0; j < n; j++) begin
                int i;
                if (mode == 0) i = j;
                else if (mode == 1) i = n - 1 - j;
                else i = (j + rot) % n;
                if (op_st[i] != 0) give_wr(op_idx[i], op_addr[i], op_data[i]);
                else give_rd(op_idx[i], op_addr[i]);
                if (b % 2 == 1) @(negedge clk);
            end
            wait_drain();
            check_mem("R7 R8");
        end

        finish_run();
    end

endmodule